// File: doc/BRIEF.md
# Target Read Response Controller

This block sits beside the bus engine of a target device and makes the per-transaction decisions for data that flows from the target to the controller. When a private or legacy read request arrives it answers ACK or NACK. The answer depends on whether the transmit FIFO holds data, on a software force-NACK policy bit, and on a one-time ACK override that software can arm.

Once a transfer is running, which is either an ACKed private read or an in-band-interrupt payload, the bus engine strobes the block once per data byte. The block answers with the transition bit for that byte: continue, or end of data. It ends the transfer when the FIFO is about to run dry, or when the byte count reaches the length limit for that kind of transfer. The serial shifter and the FIFO storage are outside the block. The block only reads the FIFO occupancy.

Top module: `rd_resp_ctrl`

## Requirements
- R1: After reset, resp_valid, tbit_valid, xfer_active and ack_once_armed are all 0.
- R2: A private request (req_valid=1, req_ibi=0) seen while fifo_count is 0 is answered one cycle later with resp_valid=1 and resp_ack=0, whatever the policy bits are, and it leaves ack_once_armed unchanged.
- R3: A private request with fifo_count above 0 and force_nack=0 is answered one cycle later with resp_ack=1, and xfer_active becomes 1.
- R4: With force_nack=1 and no armed override, a private request is answered with resp_ack=0 even when the FIFO holds data, and xfer_active becomes 0.
- R5: With force_nack=1, an armed override and fifo_count above 0, a private request is ACKed and the override clears, so the next such request is NACKed.
- R6: A pulse on ack_once_set arms the override (ack_once_armed=1 from the next cycle). If the pulse coincides with a request that consumes the override, the override stays armed.
- R7: A byte_strobe during a transfer produces tbit_valid=1 one cycle later. tbit_more is 1 when fifo_count at the strobe is 2 or more and no length limit is reached by this byte.
- R8: A byte_strobe with fifo_count of 1 or less gives tbit_more=0, and xfer_active falls in the same cycle.
- R9: In a private read with max_read_len=N (N>0), the Nth byte carries tbit_more=0 and ends the transfer, even though the FIFO still holds data.
- R10: A request with req_ibi=1 starts a payload transfer with no ACK/NACK response. Its bytes are limited by ibi_len_limit and not by max_read_len.
- R11: A limit value of 0 means that no length limit applies.
- R12: The byte count restarts from zero at every transfer start.
- R13: A byte_strobe while no transfer is active is ignored: no tbit_valid follows and xfer_active stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle pulse: a read request or a payload start |
| req_ibi | input | 1 | 0 = private/legacy read request, 1 = in-band-interrupt payload start |
| fifo_count | input | CNT_W | Transmit FIFO occupancy, counting the byte now being sent |
| force_nack | input | 1 | Policy: NACK private reads unless the override is armed |
| ack_once_set | input | 1 | One-cycle pulse that arms the one-time ACK override |
| max_read_len | input | LEN_W | Byte limit for private reads, 0 = no limit |
| ibi_len_limit | input | LEN_W | Byte limit for interrupt payloads, 0 = no limit |
| byte_strobe | input | 1 | One-cycle pulse per data byte from the bus engine |
| resp_valid | output | 1 | Response to a private request is present |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK, meaningful with resp_valid |
| tbit_valid | output | 1 | Transition bit for the last strobed byte is present |
| tbit_more | output | 1 | 1 = more data follows, 0 = end of data |
| xfer_active | output | 1 | A transfer is in progress |
| ack_once_armed | output | 1 | The one-time ACK override is armed |

## Verification
The assertions assume that req_valid and byte_strobe never rise in the same cycle, and that fifo_count does not change inside a cycle that carries a strobe. They also assume that the bus engine only strobes bytes of a transfer it is running. The stimulus issues every request, strobe or arming pulse as a single-cycle pulse followed by a quiet cycle, so no two events overlap. The one deliberate overlap is the arming pulse issued together with a consuming request, which exercises the same-cycle priority.

// File: rtl/rd_resp_pkg.sv
package rd_resp_pkg;

    typedef enum logic {
        XFER_PRIV = 1'b0,
        XFER_IBI  = 1'b1
    } xfer_kind_e;

    typedef struct packed {
        logic valid;
        logic ack;
    } resp_t;

    typedef struct packed {
        logic valid;
        logic more;
    } tbit_t;

    // True when a nonzero limit is met by the count of bytes sent so far.
    function automatic logic limit_hit(input logic [31:0] sent, input logic [31:0] limit);
        return (limit != 32'd0) && (sent >= limit);
    endfunction

    // ACK rule for a private request.
    function automatic logic grant_read(input logic has_data, input logic forced,
                                        input logic armed);
        return has_data && (!forced || armed);
    endfunction

endpackage

// File: rtl/rd_ack_decider.sv
module rd_ack_decider
    import rd_resp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  xfer_kind_e       req_kind,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             force_nack,
    input  logic             ack_once_set,
    output resp_t            resp,
    output logic             armed,
    output logic             grant,
    output logic             refuse
);

    logic priv_req;
    logic has_data;
    logic consume;
    logic armed_q;

    assign priv_req = req_valid && (req_kind == XFER_PRIV);
    assign has_data = (fifo_count != '0);
    assign grant    = priv_req && grant_read(has_data, force_nack, armed_q);
    assign refuse   = priv_req && !grant;
    assign consume  = grant && force_nack;
    assign armed    = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            resp    <= '0;
        end else begin
            armed_q    <= ack_once_set || (armed_q && !consume);
            resp.valid <= priv_req;
            resp.ack   <= grant;
        end
    end

    // R2
    empty_nack_chk: assert property (@(posedge clk) disable iff (rst)
        priv_req && !has_data |=> resp.valid && !resp.ack);

    // R4
    forced_nack_chk: assert property (@(posedge clk) disable iff (rst)
        priv_req && force_nack && !armed_q |=> resp.valid && !resp.ack);

    // R5
    once_clear_chk: assert property (@(posedge clk) disable iff (rst)
        priv_req && force_nack && armed_q && has_data && !ack_once_set |=> !armed_q);

    // R6
    once_arm_chk: assert property (@(posedge clk) disable iff (rst)
        ack_once_set |=> armed_q);

endmodule

// File: rtl/rd_len_tracker.sv
module rd_len_tracker
    import rd_resp_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  xfer_kind_e       start_kind,
    input  logic             stop,
    input  logic             byte_strobe,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [LEN_W-1:0] max_read_len,
    input  logic [LEN_W-1:0] ibi_len_limit,
    output tbit_t            tbit,
    output logic             active
);

    localparam int SENT_W = LEN_W + 1;

    logic             active_q;
    xfer_kind_e       kind_q;
    logic [LEN_W-1:0] sent_q;
    logic [SENT_W-1:0] sent_next;
    logic [LEN_W-1:0] limit_sel;
    logic             take_byte;
    logic             more_data;
    logic             more;

    assign take_byte = byte_strobe && active_q && !start && !stop;
    assign sent_next = {1'b0, sent_q} + SENT_W'(1);
    assign limit_sel = (kind_q == XFER_IBI) ? ibi_len_limit : max_read_len;
    assign more_data = (fifo_count > CNT_W'(1));
    assign more      = more_data && !limit_hit(32'(sent_next), 32'(limit_sel));
    assign active    = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            kind_q   <= XFER_PRIV;
            sent_q   <= '0;
            tbit     <= '0;
        end else begin
            tbit.valid <= take_byte;
            tbit.more  <= take_byte && more;
            if (start) begin
                active_q <= 1'b1;
                kind_q   <= start_kind;
                sent_q   <= '0;
            end else if (stop) begin
                active_q <= 1'b0;
            end else if (take_byte) begin
                sent_q <= sent_next[LEN_W-1:0];
                if (!more) active_q <= 1'b0;
            end
        end
    end

    // R7
    tbit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tbit.valid |-> $past(byte_strobe));

    // R8
    last_byte_chk: assert property (@(posedge clk) disable iff (rst)
        byte_strobe && active_q && !start && !stop && fifo_count <= CNT_W'(1)
        |=> tbit.valid && !tbit.more && !active_q);

    // R13
    idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        byte_strobe && !active_q && !start |=> !tbit.valid && !active_q);

    // R8
    end_drops_chk: assert property (@(posedge clk) disable iff (rst)
        tbit.valid && !tbit.more |-> !active_q);

endmodule

// File: rtl/rd_resp_ctrl.sv
module rd_resp_ctrl
    import rd_resp_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_ibi,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             force_nack,
    input  logic             ack_once_set,
    input  logic [LEN_W-1:0] max_read_len,
    input  logic [LEN_W-1:0] ibi_len_limit,
    input  logic             byte_strobe,
    output logic             resp_valid,
    output logic             resp_ack,
    output logic             tbit_valid,
    output logic             tbit_more,
    output logic             xfer_active,
    output logic             ack_once_armed
);

    xfer_kind_e kind;
    resp_t      resp;
    tbit_t      tbit;
    logic       grant;
    logic       refuse;
    logic       ibi_start;
    logic       start;

    assign kind      = req_ibi ? XFER_IBI : XFER_PRIV;
    assign ibi_start = req_valid && req_ibi;
    assign start     = grant || ibi_start;

    rd_ack_decider #(.CNT_W(CNT_W)) u_ack (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_kind     (kind),
        .fifo_count   (fifo_count),
        .force_nack   (force_nack),
        .ack_once_set (ack_once_set),
        .resp         (resp),
        .armed        (ack_once_armed),
        .grant        (grant),
        .refuse       (refuse)
    );

    rd_len_tracker #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_len (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .start_kind    (kind),
        .stop          (refuse),
        .byte_strobe   (byte_strobe),
        .fifo_count    (fifo_count),
        .max_read_len  (max_read_len),
        .ibi_len_limit (ibi_len_limit),
        .tbit          (tbit),
        .active        (xfer_active)
    );

    assign resp_valid = resp.valid;
    assign resp_ack   = resp.ack;
    assign tbit_valid = tbit.valid;
    assign tbit_more  = tbit.more;

    // R10
    ibi_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ibi_start |=> !resp_valid && xfer_active);

    // R3
    ack_starts_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_ack |-> xfer_active);

endmodule

// File: tb/rd_resp_ctrl_test.sv
`timescale 1ns/1ps
module rd_resp_ctrl_test;

    localparam int CNT_W = 5;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ibi = 1'b0;
    logic [CNT_W-1:0] fifo_count = '0;
    logic             force_nack = 1'b0;
    logic             ack_once_set = 1'b0;
    logic [LEN_W-1:0] max_read_len = '0;
    logic [LEN_W-1:0] ibi_len_limit = '0;
    logic             byte_strobe = 1'b0;
    logic             resp_valid, resp_ack, tbit_valid, tbit_more;
    logic             xfer_active, ack_once_armed;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit    is_tbit;
        bit    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    // reference state derived from the requirements
    bit m_armed = 0;
    bit m_active = 0;
    bit m_ibi = 0;
    int m_sent = 0;

    always #4 clk = ~clk;

    rd_resp_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ibi(req_ibi),
        .fifo_count(fifo_count), .force_nack(force_nack), .ack_once_set(ack_once_set),
        .max_read_len(max_read_len), .ibi_len_limit(ibi_len_limit),
        .byte_strobe(byte_strobe), .resp_valid(resp_valid), .resp_ack(resp_ack),
        .tbit_valid(tbit_valid), .tbit_more(tbit_more), .xfer_active(xfer_active),
        .ack_once_armed(ack_once_armed)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst && (resp_valid || tbit_valid)) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R13: actual unexpected output (resp %b tbit %b) expected none",
                         resp_valid, tbit_valid);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_tbit != tbit_valid || e.is_tbit == resp_valid ||
                    (e.is_tbit ? tbit_more : resp_ack) != e.val) begin
                    fails++;
                    $display("FAIL %s: actual resp %b/%b tbit %b/%b expected %s=%b",
                             e.tag, resp_valid, resp_ack, tbit_valid, tbit_more,
                             e.is_tbit ? "tbit" : "ack", e.val);
                end
            end
        end
    end

    task automatic send_req(input bit ibi, input int cnt, input bit set_once, input string tag);
        @(posedge clk); #1;
        req_valid = 1'b1; req_ibi = ibi; fifo_count = CNT_W'(cnt); ack_once_set = set_once;
        if (ibi) begin
            m_active = 1; m_ibi = 1; m_sent = 0;
        end else begin
            bit ack;
            ack = (cnt != 0) && (!force_nack || m_armed);
            if (ack && force_nack) m_armed = 0;
            sb.push_back('{0, ack, tag});
            m_active = ack; m_ibi = 0;
            if (ack) m_sent = 0;
        end
        if (set_once) m_armed = 1;
        @(posedge clk); #1;
        req_valid = 1'b0; ack_once_set = 1'b0;
    endtask

    task automatic strobe(input int cnt, input string tag);
        @(posedge clk); #1;
        byte_strobe = 1'b1; fifo_count = CNT_W'(cnt);
        if (m_active) begin
            int lim;
            bit more;
            lim = m_ibi ? int'(ibi_len_limit) : int'(max_read_len);
            m_sent++;
            more = (cnt >= 2) && !(lim != 0 && m_sent >= lim);
            sb.push_back('{1, more, tag});
            if (!more) m_active = 0;
        end
        @(posedge clk); #1;
        byte_strobe = 1'b0;
    endtask

    task automatic arm();
        @(posedge clk); #1;
        ack_once_set = 1'b1; m_armed = 1;
        @(posedge clk); #1;
        ack_once_set = 1'b0;
    endtask

    task automatic state_check(input string tag);
        @(negedge clk);
        check({tag, " active"}, xfer_active, m_active);
        check({tag, " armed"}, ack_once_armed, m_armed);
    endtask

    task automatic finish_run();
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 resp_valid", resp_valid, 1'b0);
        check("R1 tbit_valid", tbit_valid, 1'b0);
        check("R1 active", xfer_active, 1'b0);
        check("R1 armed", ack_once_armed, 1'b0);

        // R2: empty FIFO
        send_req(0, 0, 0, "R2 empty nack");
        state_check("R2");

        // R3, R7, R8
        send_req(0, 5, 0, "R3 ack");
        state_check("R3");
        strobe(5, "R7 more");
        strobe(4, "R7 more");
        strobe(3, "R7 more");
        strobe(1, "R8 last");
        state_check("R8");

        // R13
        strobe(6, "R13 idle");
        state_check("R13");

        // R9, R12
        max_read_len = 8'd3;
        send_req(0, 9, 0, "R9 ack");
        strobe(9, "R9 byte1");
        strobe(8, "R9 byte2");
        strobe(7, "R9 byte3 limit");
        state_check("R9");
        send_req(0, 9, 0, "R12 ack");
        strobe(9, "R12 byte1");
        strobe(8, "R12 byte2");
        strobe(7, "R12 byte3 limit");
        state_check("R12");

        // R10
        ibi_len_limit = 8'd2;
        send_req(1, 9, 0, "R10 start");
        state_check("R10");
        strobe(9, "R10 byte1");
        strobe(9, "R10 byte2 limit");
        state_check("R10 end");

        // R11
        max_read_len = 8'd0;
        send_req(0, 20, 0, "R11 ack");
        for (int i = 0; i < 20; i++) strobe(20, "R11 unlimited");
        strobe(1, "R11 last");
        state_check("R11");

        // R4, R5, R6
        force_nack = 1'b1;
        send_req(0, 5, 0, "R4 forced nack");
        state_check("R4");
        arm();
        state_check("R6 arm");
        send_req(0, 0, 0, "R2 empty keeps arm");
        state_check("R2 arm kept");
        send_req(0, 5, 0, "R5 one-time ack");
        state_check("R5 cleared");
        send_req(0, 5, 0, "R5 next nack");
        state_check("R5 after");

        // R6 coincident set and consume
        arm();
        send_req(0, 5, 1, "R6 coincident ack");
        state_check("R6 coincident");
        send_req(0, 5, 0, "R6 rearmed ack");
        state_check("R6 final");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule